// File: doc/BRIEF.md
# Enabled-Channel Conversion Sequencer with Power Gating

This block drives an external converter through one pass over every enabled analog channel each time it receives a start pulse. It takes a copy of the channel enable mask when the start is accepted and then issues one conversion per set bit of that copy, lowest index first. Each result returned by the converter is stored in a per-channel result register with its own valid flag. When the last conversion of the pass completes, the block raises a one-cycle completion pulse and becomes idle again.

The enable mask is maintained through two write strobes, one that sets bits and one that clears them. In sleep mode the converter is kept unpowered while the block is idle. An accepted start powers it up, and the block then waits a programmable settling count before the first conversion. Power is removed when the pass ends. Outside sleep mode, power stays on and the settling wait is skipped.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After an accepted start, `cv_start_o` pulses exactly once for each bit set in the captured enable mask, with `cv_chan_o` giving the channel index in ascending order. No other channel is started.
- R2: A one on bit i of `en_set_i` enables channel i, and a one on bit i of `en_clr_i` disables it. When both are one in the same cycle, the channel ends up disabled. The change is effective for the next accepted start.
- R3: A start pulse is ignored while a pass is running, and this includes the cycle in which the last conversion's done is sampled. No extra conversion, power-up or completion pulse follows from it.
- R4: The enable mask is captured in the cycle the start is accepted. Writes made during a pass do not change that pass.
- R5: An accepted start clears all of `res_valid_o`. On each `cv_done_i` the matching `res_data_o` slice (channel i at bits [i*DW +: DW]) takes `cv_data_i` and its valid bit sets. At the end of a pass, `res_valid_o` equals the captured mask.
- R6: A start that arrives while the enable mask is all zero does nothing. There is no conversion, no completion pulse, no power-up and no change to `res_valid_o`.
- R7: In sleep mode `pwr_en_o` is low while the block is idle and rises in the cycle after the start is accepted. The first `cv_start_o` comes exactly `su_cycles_i`+1 cycles after `pwr_en_o` rises.
- R8: In sleep mode `pwr_en_o` falls in the same cycle that `seq_done_o` pulses.
- R9: Outside sleep mode `pwr_en_o` stays high, and the first `cv_start_o` appears in the cycle after the start is sampled.
- R10: `cv_start_o` is never high while `cv_busy_i` is high, and it lasts one cycle per conversion.
- R11: `seq_done_o` is a single-cycle pulse. It is high in the cycle after the last done is sampled, and the block is idle at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request pulse |
| sleep_i | input | 1 | 1 = power-gate the converter between passes |
| su_cycles_i | input | SUW | Settling wait after power-up, in cycles |
| en_set_i | input | NCH | Channel enable set strobes |
| en_clr_i | input | NCH | Channel enable clear strobes (take priority) |
| cv_start_o | output | 1 | Start a conversion on `cv_chan_o` |
| cv_chan_o | output | CHW | Channel index for the conversion |
| cv_busy_i | input | 1 | Converter busy |
| cv_done_i | input | 1 | Conversion finished, `cv_data_i` valid |
| cv_data_i | input | DW | Conversion result |
| pwr_en_o | output | 1 | Converter power enable |
| res_data_o | output | NCH*DW | Per-channel results, channel i at [i*DW +: DW] |
| res_valid_o | output | NCH | Per-channel result valid |
| seq_done_o | output | 1 | One-cycle end-of-pass pulse |

## Verification
The critical overlap is a new start request landing in the same cycle as the final conversion's done. If that request were accepted, it would either restart the pass or keep the converter powered. The bench provokes the overlap by holding `start_i` exactly when it sees the last `cv_done_i` of a pass. It then checks that `seq_done_o` pulses once, that power drops in sleep mode, and that no further `cv_start_o` follows. Random enable writes and stray start pulses are also placed inside running passes, to confirm that the captured mask controls each pass.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    S_IDLE    = 2'd0,
    S_STARTUP = 2'd1,
    S_NEXT    = 2'd2,
    S_CONVERT = 2'd3
  } seq_state_e;
endpackage

// File: rtl/adc_chan_enables.sv
module adc_chan_enables #(
  parameter int NCH = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] clr_i,
  output logic [NCH-1:0] en_o
);
  logic [NCH-1:0] en_q, en_d;

  always_comb begin
    en_d = (en_q | set_i) & ~clr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= en_d;
  end

  assign en_o = en_q;

  // R2: a clear strobe always leaves its channel disabled
  p_clr_wins_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((en_q & $past(clr_i)) == '0));
endmodule

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
  parameter int NCH = 8,
  parameter int CHW = 3
) (
  input  logic [NCH-1:0] mask_i,
  output logic [NCH-1:0] onehot_o,
  output logic [CHW-1:0] idx_o
);
  always_comb begin
    onehot_o = mask_i & (~mask_i + NCH'(1));
    idx_o    = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = CHW'(i);
    end
  end

  // R1: the pick is a single channel and is taken from the mask
  always_comb begin
    a_pick_onehot_r1: assert ($onehot0(onehot_o));
    if (mask_i != '0) a_pick_in_mask_r1: assert (mask_i[idx_o]);
  end
endmodule

// File: rtl/adc_startup_timer.sv
module adc_startup_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  input  logic          run_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = load_i | (run_i & (cnt_q != '0));

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)    cnt_d = val_i;
    else if (run_i) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R7: the settling count falls by one per cycle while it runs
  p_tmr_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 10,
  parameter int SUW = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sleep_i,
  input  logic [SUW-1:0]    su_cycles_i,
  input  logic [NCH-1:0]    en_set_i,
  input  logic [NCH-1:0]    en_clr_i,
  output logic              cv_start_o,
  output logic [CHW-1:0]    cv_chan_o,
  input  logic              cv_busy_i,
  input  logic              cv_done_i,
  input  logic [DW-1:0]     cv_data_i,
  output logic              pwr_en_o,
  output logic [NCH*DW-1:0] res_data_o,
  output logic [NCH-1:0]    res_valid_o,
  output logic              seq_done_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  seq_state_e     state_q, state_d;
  logic [NCH-1:0] en_q, mask_q, mask_d, pick_oh;
  logic [CHW-1:0] pick_idx, chan_q;
  logic           pwr_q, pwr_d, done_q, done_d;
  logic           accept, issue, last_done, tmr_zero, mask_en;
  logic [NCH-1:0] valid_q;

  adc_chan_enables #(.NCH(NCH)) u_enables (
    .clk_i (clk_i), .rst_ni (rst_n),
    .set_i (en_set_i), .clr_i (en_clr_i), .en_o (en_q)
  );

  adc_chan_pick #(.NCH(NCH), .CHW(CHW)) u_pick (
    .mask_i (mask_q), .onehot_o (pick_oh), .idx_o (pick_idx)
  );

  adc_startup_timer #(.CW(SUW)) u_timer (
    .clk_i (clk_i), .rst_ni (rst_n),
    .load_i (accept), .val_i (su_cycles_i),
    .run_i (state_q == S_STARTUP), .zero_o (tmr_zero)
  );

  assign accept    = (state_q == S_IDLE) && start_i && (en_q != '0);
  assign issue     = (state_q == S_NEXT) && !cv_busy_i;
  assign last_done = (state_q == S_CONVERT) && cv_done_i && (mask_q == '0);

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:    if (accept) state_d = sleep_i ? S_STARTUP : S_NEXT;
      S_STARTUP: if (tmr_zero) state_d = S_NEXT;
      S_NEXT:    if (issue) state_d = S_CONVERT;
      S_CONVERT: if (cv_done_i) state_d = (mask_q == '0) ? S_IDLE : S_NEXT;
      default:   state_d = S_IDLE;
    endcase
  end

  always_comb begin
    mask_en = accept | issue;
    mask_d  = accept ? en_q : (mask_q & ~pick_oh);
    pwr_d   = accept ? 1'b1 : (last_done ? 1'b0 : pwr_q);
    done_d  = last_done;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      pwr_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pwr_q   <= pwr_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)     chan_q <= '0;
    else if (issue) chan_q <= pick_idx;
  end

  // per-channel result slots
  for (genvar g = 0; g < NCH; g++) begin : g_slot
    logic          wr_en;
    logic [DW-1:0] data_q;
    assign wr_en = (state_q == S_CONVERT) && cv_done_i && (chan_q == CHW'(g));

    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n)     data_q <= '0;
      else if (wr_en) data_q <= cv_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n)               valid_q[g] <= 1'b0;
      else if (accept | wr_en)  valid_q[g] <= wr_en;
    end

    assign res_data_o[g*DW +: DW] = data_q;
  end

  assign cv_start_o  = issue;
  assign cv_chan_o   = pick_idx;
  assign pwr_en_o    = !sleep_i || pwr_q;
  assign res_valid_o = valid_q;
  assign seq_done_o  = done_q;

  // R7: converter unpowered when idle in sleep mode
  p_pwr_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == S_IDLE && sleep_i) |-> !pwr_en_o);
  // R7: no conversion is started without power
  p_pwr_conv_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    cv_start_o |-> pwr_en_o);
  // R10: one start pulse per conversion
  p_start_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    cv_start_o |=> !cv_start_o);
  // R1: a started channel comes from the captured mask
  p_chan_in_mask_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    cv_start_o |-> mask_q[cv_chan_o]);
  // R11: completion is one cycle long and leaves the block idle
  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_n)
    seq_done_o |=> !seq_done_o);
  p_done_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_n)
    seq_done_o |-> (state_q == S_IDLE));
  // R3: valid flags only accumulate inside a pass, so no restart occurs there
  p_no_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q != S_IDLE) |=> ((valid_q & $past(valid_q)) == $past(valid_q)));
endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;
  localparam int NCH = 8;
  localparam int DW  = 10;
  localparam int SUW = 8;
  localparam int CHW = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n, start_i, sleep_i, cv_busy_i, cv_done_i;
  logic [SUW-1:0]    su_cycles_i;
  logic [NCH-1:0]    en_set_i, en_clr_i, res_valid_o;
  logic              cv_start_o, pwr_en_o, seq_done_o;
  logic [CHW-1:0]    cv_chan_o;
  logic [DW-1:0]     cv_data_i;
  logic [NCH*DW-1:0] res_data_o;

  adc_seq_ctrl #(.NCH(NCH), .DW(DW), .SUW(SUW)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start_i), .sleep_i (sleep_i),
    .su_cycles_i (su_cycles_i), .en_set_i (en_set_i), .en_clr_i (en_clr_i),
    .cv_start_o (cv_start_o), .cv_chan_o (cv_chan_o), .cv_busy_i (cv_busy_i),
    .cv_done_i (cv_done_i), .cv_data_i (cv_data_i), .pwr_en_o (pwr_en_o),
    .res_data_o (res_data_o), .res_valid_o (res_valid_o), .seq_done_o (seq_done_o)
  );

  int total = 0;
  int bad   = 0;
  logic [NCH-1:0] mirror;
  logic [DW-1:0]  salt;

  function automatic logic [DW-1:0] exp_data(int ch, logic [DW-1:0] s);
    return DW'(ch * 53) + s;
  endfunction

  function automatic int lowest(logic [NCH-1:0] m);
    for (int i = 0; i < NCH; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model: random latency, optional busy tail after done
  logic [2:0]     m_cnt;
  logic           m_tail, m_tail_en;
  logic [CHW-1:0] m_ch;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cv_busy_i <= 1'b0; cv_done_i <= 1'b0; cv_data_i <= '0;
      m_cnt <= '0; m_tail <= 1'b0; m_tail_en <= 1'b0; m_ch <= '0;
    end else begin
      cv_done_i <= 1'b0;
      if (m_cnt != 0) begin
        m_cnt <= m_cnt - 1'b1;
        if (m_cnt == 1) begin
          cv_done_i <= 1'b1;
          cv_data_i <= exp_data(int'(m_ch), salt);
          if (m_tail_en) m_tail <= 1'b1;
          else           cv_busy_i <= 1'b0;
        end
      end else if (m_tail) begin
        m_tail <= 1'b0;
        cv_busy_i <= 1'b0;
      end else if (cv_start_o) begin
        cv_busy_i <= 1'b1;
        m_ch      <= cv_chan_o;
        m_cnt     <= 3'(1 + $urandom % 4);
        m_tail_en <= 1'($urandom % 2);
      end
    end
  end

  task automatic wr(logic [NCH-1:0] s, logic [NCH-1:0] c);
    @(negedge clk);
    en_set_i = s; en_clr_i = c;
    mirror = (mirror | s) & ~c;
    @(negedge clk);
    en_set_i = '0; en_clr_i = '0;
  endtask

  task automatic run_seq(bit slp, int su, bit poke_end);
    logic [NCH-1:0] exp, rem;
    int cyc, first, lo;
    bit finished;
    @(negedge clk);
    sleep_i = slp; su_cycles_i = SUW'(su);
    @(negedge clk);
    chk(pwr_en_o == !slp, slp ? "R7 idle power" : "R9 power", int'(pwr_en_o), int'(!slp));
    exp = mirror; rem = exp; salt = DW'($urandom);
    start_i = 1'b1;
    cyc = 0; first = -1; finished = 0;
    while (!finished) begin
      @(negedge clk);
      cyc++;
      start_i = 1'b0; en_set_i = '0; en_clr_i = '0;
      if (slp && cyc == 1) chk(pwr_en_o == 1'b1, "R7 power-up", int'(pwr_en_o), 1);
      if (!slp) chk(pwr_en_o == 1'b1, "R9 power held", int'(pwr_en_o), 1);
      if (cv_start_o) begin
        chk(!cv_busy_i, "R10 start while busy", int'(cv_busy_i), 0);
        lo = lowest(rem);
        chk(lo >= 0 && int'(cv_chan_o) == lo, "R1 channel order", int'(cv_chan_o), lo);
        if (lo >= 0) rem[lo] = 1'b0;
        if (first < 0) begin
          first = cyc;
          chk(first == (slp ? su + 2 : 1), slp ? "R7 settle wait" : "R9 first start", first,
              slp ? su + 2 : 1);
        end
      end
      if (seq_done_o) begin
        finished = 1;
        chk(rem == '0, "R1 channels left", int'(rem), 0);
        chk(pwr_en_o == !slp, "R8 power at done", int'(pwr_en_o), int'(!slp));
        chk(res_valid_o == exp, "R4,R5 valid flags", int'(res_valid_o), int'(exp));
        for (int ch = 0; ch < NCH; ch++)
          if (exp[ch])
            chk(res_data_o[ch*DW +: DW] == exp_data(ch, salt), "R5 data",
                int'(res_data_o[ch*DW +: DW]), int'(exp_data(ch, salt)));
      end else begin
        if (cv_done_i && rem == '0 && poke_end) start_i = 1'b1;
        else if (rem != '0 && $urandom % 6 == 0) start_i = 1'b1;
        if ($urandom % 8 == 0) begin
          en_set_i = NCH'($urandom); en_clr_i = NCH'($urandom);
          mirror = (mirror | en_set_i) & ~en_clr_i;
        end
      end
      if (cyc > 3000) begin
        chk(0, "R1 pass never finished", cyc, 0);
        finished = 1;
      end
    end
    @(negedge clk);
    chk(!seq_done_o, "R11 done width", int'(seq_done_o), 0);
    for (int k = 0; k < 5; k++) begin
      chk(!cv_start_o, "R3 ignored start", int'(cv_start_o), 0);
      @(negedge clk);
    end
  endtask

  task automatic run_empty(bit slp);
    logic [NCH-1:0] v0;
    @(negedge clk);
    sleep_i = slp;
    v0 = res_valid_o;
    start_i = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      start_i = 1'b0;
      chk(!cv_start_o && !seq_done_o, "R6 empty start", int'(cv_start_o), 0);
      chk(pwr_en_o == !slp, "R6 empty power", int'(pwr_en_o), int'(!slp));
    end
    chk(res_valid_o == v0, "R6 valid kept", int'(res_valid_o), int'(v0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; start_i = 1'b0; sleep_i = 1'b1; su_cycles_i = '0;
    en_set_i = '0; en_clr_i = '0; mirror = '0; salt = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(pwr_en_o == 1'b0, "R7 reset power", int'(pwr_en_o), 0);
    chk(res_valid_o == '0, "R5 reset valid", int'(res_valid_o), 0);
    chk(!seq_done_o && !cv_start_o, "R11 reset outputs", int'(seq_done_o), 0);

    wr(8'h81, 8'h00);
    run_seq(1'b1, 0, 1'b0);
    wr(8'h10, 8'h10);
    run_seq(1'b0, 3, 1'b1);
    chk(res_valid_o[4] == 1'b0, "R2 clear wins", int'(res_valid_o[4]), 0);
    wr(8'hFF, 8'h00);
    run_seq(1'b1, 12, 1'b1);
    run_seq(1'b0, 0, 1'b1);
    wr(8'h00, 8'hFF);
    run_empty(1'b1);
    run_empty(1'b0);
    wr(8'h01, 8'h00);
    run_seq(1'b1, 5, 1'b1);

    for (int it = 0; it < 40; it++) begin
      wr(NCH'($urandom), NCH'($urandom));
      if (mirror == '0) wr(NCH'(1) << ($urandom % NCH), '0);
      run_seq(1'($urandom % 2), int'($urandom % 13), 1'($urandom % 2));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule